// File: doc/BRIEF.md
# Region-Aware DRAM Activation and Precharge Timer

This block sits inside a memory controller's command scheduler. For each bank it follows the row state (closed, opening, open, closing) and counts down the wait that must pass before the next dependent command. That wait is ACTIVATE to column command (row-to-column delay) and PRECHARGE to the next ACTIVATE (precharge delay). The wait is not one global value. It is taken from two small profiled tables that give each memory region a latency class. Slowness in activation clusters by column and slowness in precharge clusters by row, so the activation class is looked up by the upper column bits and the precharge class by the upper row bits, each in its own table. Addresses and data pass the block untouched, so software cannot see it.

Each class code selects one of three cycle counts, set by parameters: fast (near 7.5 ns), middle (10 ns, where every cell is reliable) and standard (near 13 ns). For the precharge wait the scheduler supplies the region of the row it will activate next. When that row is not yet known, the standard count is used. After reset every table entry holds the standard class. A simple write port loads the tables, and it accepts writes only while no bank timer is running. Each bank has one state machine with states CLOSED, ACTIVATING, OPEN and PRECHARGING. The transitions are CLOSED to ACTIVATING on ACTIVATE, ACTIVATING to OPEN when the timer reaches zero, OPEN to PRECHARGING on PRECHARGE, and PRECHARGING to CLOSED when the timer reaches zero.

Top module: `dram_lat_select`

## Requirements
- R1: After reset every bank reports act_rdy=1, col_rdy=0 and pre_rdy=0, and every table entry holds class 2, so the first waits are CYC_STD cycles.
- R2: An ACTIVATE (cmd_op=0) to a bank in CLOSED raises that bank's col_rdy and pre_rdy exactly N cycles after the command edge. N comes from the row-to-column table entry indexed by cmd_rcd_rgn.
- R3: A PRECHARGE (cmd_op=3) to an OPEN bank with cmd_next_known=1 raises act_rdy exactly N cycles after the command edge. N comes from the precharge table entry indexed by cmd_rp_rgn.
- R4: A PRECHARGE with cmd_next_known=0 always waits CYC_STD cycles, whatever the table holds.
- R5: Class code 0 maps to CYC_FAST, code 1 to CYC_MID, and codes 2 and 3 to CYC_STD.
- R6: A command that does not fit the bank's state has no effect. This covers READ (1) or WRITE (2) on a closed bank, PRECHARGE on a closed bank, and ACTIVATE on an open bank.
- R7: The two tables are separate. tbl_wr_sel=0 writes the row-to-column table and tbl_wr_sel=1 writes the precharge table at tbl_wr_idx, and neither write changes the other table.
- R8: A table write presented while any bank is ACTIVATING or PRECHARGING is dropped.
- R9: A command changes only the bank named by cmd_bank.
- R10: READ and WRITE to an open bank leave it open with col_rdy and pre_rdy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | input | BANK_W | Target bank |
| cmd_rcd_rgn | input | RCD_IDX_W | Upper column bits of the target access (row-to-column region) |
| cmd_rp_rgn | input | RP_IDX_W | Upper row bits of the row to activate next (precharge region) |
| cmd_next_known | input | 1 | With PRECHARGE, cmd_rp_rgn names a known next row |
| tbl_wr_en | input | 1 | Table write request |
| tbl_wr_sel | input | 1 | 0 row-to-column table, 1 precharge table |
| tbl_wr_idx | input | TBL_IDX_W | Region index to write |
| tbl_wr_class | input | 2 | Class code to store |
| act_rdy | output | NUM_BANKS | Bank may take ACTIVATE |
| col_rdy | output | NUM_BANKS | Bank may take READ or WRITE |
| pre_rdy | output | NUM_BANKS | Bank may take PRECHARGE |

## Verification
The waits are measured at the ready outputs for every class code in both tables. Each code is reached through a different region index, so a wrong index decode or a wrong class mapping gives a distinct wrong count. Precharges are issued with the next row known and unknown over a region programmed fast, which tells the worst-case fallback apart from the table path. A fast entry is placed in the row-to-column table at an index whose precharge entry stays slow, which shows that the two tables do not alias. Writes are attempted while a bank is counting and while all banks are idle. Commands are sent in the wrong state and to neighbouring banks, and the bench checks that the targeted and untouched banks keep their state.

// File: rtl/dram_lat_pkg.sv
package dram_lat_pkg;

    localparam int CLS_W = 2;
    localparam logic [CLS_W-1:0] CLS_FAST = 2'd0;
    localparam logic [CLS_W-1:0] CLS_MID  = 2'd1;
    localparam logic [CLS_W-1:0] CLS_STD  = 2'd2;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        S_CLOSED      = 2'd0,
        S_ACTIVATING  = 2'd1,
        S_OPEN        = 2'd2,
        S_PRECHARGING = 2'd3
    } bank_state_e;

    // Class code to wait in cycles; codes above the middle class fall back to standard.
    function automatic int unsigned cls_to_cycles(input logic [CLS_W-1:0] cls,
                                                  input int unsigned fast_c,
                                                  input int unsigned mid_c,
                                                  input int unsigned std_c);
        unique case (cls)
            CLS_FAST: return fast_c;
            CLS_MID:  return mid_c;
            default:  return std_c;
        endcase
    endfunction

endpackage

// File: rtl/lat_class_table.sv
module lat_class_table
    import dram_lat_pkg::*;
#(
    parameter int IDX_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [CLS_W-1:0]       wr_class,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [CLS_W-1:0]       rd_class,
    output logic [DEPTH*CLS_W-1:0] contents
);

    logic [DEPTH*CLS_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= {DEPTH{CLS_STD}};
        end else if (wr_en) begin
            mem_q[wr_idx*CLS_W +: CLS_W] <= wr_class;
        end
    end

    assign rd_class = mem_q[rd_idx*CLS_W +: CLS_W];
    assign contents = mem_q;

endmodule

// File: rtl/bank_timer.sv
module bank_timer
    import dram_lat_pkg::*;
#(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [TMR_W-1:0] act_cyc,
    input  logic [TMR_W-1:0] pre_cyc,
    output logic             act_rdy,
    output logic             col_rdy,
    output logic             pre_rdy,
    output logic             busy
);

    bank_state_e state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            S_CLOSED: begin
                if (act_go) begin
                    state_d = S_ACTIVATING;
                    tmr_d   = act_cyc - TMR_W'(1);
                end
            end
            S_ACTIVATING: begin
                if (tmr_q == '0) state_d = S_OPEN;
                else             tmr_d   = tmr_q - TMR_W'(1);
            end
            S_OPEN: begin
                if (pre_go) begin
                    state_d = S_PRECHARGING;
                    tmr_d   = pre_cyc - TMR_W'(1);
                end
            end
            S_PRECHARGING: begin
                if (tmr_q == '0) state_d = S_CLOSED;
                else             tmr_d   = tmr_q - TMR_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_CLOSED;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        act_rdy = 1'b0;
        col_rdy = 1'b0;
        pre_rdy = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            S_CLOSED:      act_rdy = 1'b1;
            S_OPEN:        begin col_rdy = 1'b1; pre_rdy = 1'b1; end
            S_ACTIVATING,
            S_PRECHARGING: busy = 1'b1;
        endcase
    end

    assert_closed_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_CLOSED |=> (state_q == S_CLOSED || state_q == S_ACTIVATING));

    assert_open_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_OPEN |=> (state_q == S_OPEN || state_q == S_PRECHARGING));

    assert_act_leads_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ACTIVATING |=> (state_q == S_ACTIVATING || state_q == S_OPEN));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr_q != '0) |=> (busy && tmr_q == $past(tmr_q) - TMR_W'(1)));

endmodule

// File: rtl/dram_lat_select.sv
module dram_lat_select
    import dram_lat_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RCD_IDX_W = 2,
    parameter int RP_IDX_W  = 3,
    parameter int CYC_FAST  = 6,
    parameter int CYC_MID   = 8,
    parameter int CYC_STD   = 11,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int TBL_IDX_W = (RCD_IDX_W > RP_IDX_W) ? RCD_IDX_W : RP_IDX_W,
    localparam int TMR_W     = $clog2(CYC_STD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [RCD_IDX_W-1:0] cmd_rcd_rgn,
    input  logic [RP_IDX_W-1:0]  cmd_rp_rgn,
    input  logic                 cmd_next_known,
    input  logic                 tbl_wr_en,
    input  logic                 tbl_wr_sel,
    input  logic [TBL_IDX_W-1:0] tbl_wr_idx,
    input  logic [1:0]           tbl_wr_class,
    output logic [NUM_BANKS-1:0] act_rdy,
    output logic [NUM_BANKS-1:0] col_rdy,
    output logic [NUM_BANKS-1:0] pre_rdy
);

    localparam int RCD_DEPTH = 1 << RCD_IDX_W;
    localparam int RP_DEPTH  = 1 << RP_IDX_W;

    logic [NUM_BANKS-1:0] bank_busy;
    logic                 any_busy;
    logic                 rcd_we, rp_we;
    logic [CLS_W-1:0]     rcd_cls, rp_cls, rp_cls_eff;
    logic [TMR_W-1:0]     act_cyc, pre_cyc;
    logic [RCD_DEPTH*CLS_W-1:0] rcd_vec;
    logic [RP_DEPTH*CLS_W-1:0]  rp_vec;

    assign any_busy = |bank_busy;
    assign rcd_we   = tbl_wr_en && !any_busy && !tbl_wr_sel;
    assign rp_we    = tbl_wr_en && !any_busy &&  tbl_wr_sel;

    lat_class_table #(.IDX_W(RCD_IDX_W)) u_rcd_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(rcd_we),
        .wr_idx(tbl_wr_idx[RCD_IDX_W-1:0]), .wr_class(tbl_wr_class),
        .rd_idx(cmd_rcd_rgn), .rd_class(rcd_cls), .contents(rcd_vec)
    );

    lat_class_table #(.IDX_W(RP_IDX_W)) u_rp_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(rp_we),
        .wr_idx(tbl_wr_idx[RP_IDX_W-1:0]), .wr_class(tbl_wr_class),
        .rd_idx(cmd_rp_rgn), .rd_class(rp_cls), .contents(rp_vec)
    );

    assign rp_cls_eff = cmd_next_known ? rp_cls : CLS_STD;
    assign act_cyc = TMR_W'(cls_to_cycles(rcd_cls, CYC_FAST, CYC_MID, CYC_STD));
    assign pre_cyc = TMR_W'(cls_to_cycles(rp_cls_eff, CYC_FAST, CYC_MID, CYC_STD));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = cmd_vld && (cmd_bank == BANK_W'(b));
        bank_timer #(.TMR_W(TMR_W)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .act_go(hit && cmd_op == OP_ACT),
            .pre_go(hit && cmd_op == OP_PRE),
            .act_cyc(act_cyc), .pre_cyc(pre_cyc),
            .act_rdy(act_rdy[b]), .col_rdy(col_rdy[b]), .pre_rdy(pre_rdy[b]),
            .busy(bank_busy[b])
        );
    end

    assert_tbl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy |=> ($stable(rcd_vec) && $stable(rp_vec)));

    assert_bank_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> ($stable(act_rdy) || any_busy || $past(any_busy)));

endmodule

// File: tb/tb_dram_lat_select.sv
module tb_dram_lat_select;

    localparam int NB = 4, RCDW = 2, RPW = 3;
    localparam int FAST = 6, MID = 8, STD = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_vld = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [RCDW-1:0] cmd_rcd_rgn = '0;
    logic [RPW-1:0] cmd_rp_rgn = '0;
    logic cmd_next_known = 1'b0;
    logic tbl_wr_en = 1'b0, tbl_wr_sel = 1'b0;
    logic [2:0] tbl_wr_idx = '0;
    logic [1:0] tbl_wr_class = '0;
    logic [NB-1:0] act_rdy, col_rdy, pre_rdy;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dram_lat_select dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_rcd_rgn(cmd_rcd_rgn), .cmd_rp_rgn(cmd_rp_rgn),
        .cmd_next_known(cmd_next_known), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_sel(tbl_wr_sel), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_class(tbl_wr_class), .act_rdy(act_rdy), .col_rdy(col_rdy),
        .pre_rdy(pre_rdy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int bank, input int rcd,
                         input int rp, input logic known);
        cmd_vld = 1'b1; cmd_op = op; cmd_bank = 2'(bank);
        cmd_rcd_rgn = RCDW'(rcd); cmd_rp_rgn = RPW'(rp); cmd_next_known = known;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_next_known = 1'b0;
    endtask

    task automatic tbl_write(input logic sel, input int idx, input int cls);
        tbl_wr_en = 1'b1; tbl_wr_sel = sel; tbl_wr_idx = 3'(idx); tbl_wr_class = 2'(cls);
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Counts low samples of the chosen ready after a command; which 0 = col_rdy, 1 = act_rdy.
    task automatic wait_rdy(input int bank, input int which, output int n);
        n = 0;
        while (((which == 0) ? col_rdy[bank] : act_rdy[bank]) == 1'b0 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic act_meas(input int bank, input int rgn, input int exp, input string req);
        int n;
        issue(2'd0, bank, rgn, 0, 1'b0);
        wait_rdy(bank, 0, n);
        check(req, n, exp);
    endtask

    task automatic pre_meas(input int bank, input int rgn, input logic known,
                            input int exp, input string req);
        int n;
        issue(2'd3, bank, 0, rgn, known);
        wait_rdy(bank, 1, n);
        check(req, n, exp);
    endtask

    task automatic t_reset;
        check("R1 act_rdy", int'(act_rdy), 4'hF);
        check("R1 col_rdy", int'(col_rdy), 0);
        check("R1 pre_rdy", int'(pre_rdy), 0);
        act_meas(0, 0, STD, "R1 R2 default tRCD");
        pre_meas(0, 0, 1'b1, STD, "R1 R3 default tRP");
    endtask

    task automatic t_classes;
        tbl_write(1'b0, 1, 0);
        tbl_write(1'b0, 2, 1);
        tbl_write(1'b0, 3, 3);
        tbl_write(1'b1, 5, 0);
        tbl_write(1'b1, 3, 1);
        act_meas(0, 1, FAST, "R2 R5 code0 tRCD");
        pre_meas(0, 5, 1'b0, STD, "R4 unknown row uses standard");
        act_meas(0, 2, MID, "R2 R5 code1 tRCD");
        pre_meas(0, 5, 1'b1, FAST, "R3 R5 code0 tRP");
        act_meas(0, 3, STD, "R5 code3 tRCD");
        pre_meas(0, 3, 1'b1, MID, "R3 R5 code1 tRP");
        act_meas(0, 0, STD, "R2 untouched region");
        pre_meas(0, 1, 1'b1, STD, "R7 rp idx1 not aliased");
    endtask

    task automatic t_busy_write;
        int n;
        issue(2'd0, 1, 0, 0, 1'b0);
        tbl_write(1'b0, 0, 0);
        tbl_write(1'b1, 0, 0);
        wait_rdy(1, 0, n);
        pre_meas(1, 0, 1'b1, STD, "R8 rp write dropped");
        act_meas(1, 0, STD, "R8 rcd write dropped");
        pre_meas(1, 0, 1'b0, STD, "R8 close bank1");
    endtask

    task automatic t_illegal;
        issue(2'd1, 2, 0, 0, 1'b0);
        issue(2'd3, 2, 0, 0, 1'b1);
        @(negedge clk);
        check("R6 cmds on closed bank", int'({act_rdy[2], col_rdy[2], pre_rdy[2]}), 3'b100);
        act_meas(2, 1, FAST, "R6 bank2 opens");
        issue(2'd0, 2, 0, 0, 1'b0);
        @(negedge clk);
        check("R6 act on open bank", int'({act_rdy[2], col_rdy[2], pre_rdy[2]}), 3'b011);
        issue(2'd1, 2, 0, 0, 1'b0);
        issue(2'd2, 2, 0, 0, 1'b0);
        check("R10 rd wr keep open", int'({act_rdy[2], col_rdy[2], pre_rdy[2]}), 3'b011);
    endtask

    task automatic t_banks;
        issue(2'd0, 3, 0, 0, 1'b0);
        check("R9 bank2 still open", int'(col_rdy[2]), 1);
        check("R9 bank0 still closed", int'(act_rdy[0]), 1);
        check("R9 bank3 started", int'({act_rdy[3], col_rdy[3]}), 0);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_classes;
        t_busy_write;
        t_illegal;
        t_banks;
        repeat (20) @(negedge clk);
        report;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report;
    end

endmodule